// File: doc/BRIEF.md
# Address Decoder with RAM Write Protection

This block sits between a processor's bus port and its memories. It looks at each access address and classifies it as a hit in the boot ROM space, a hit in the main RAM space, or a hit in a 256-byte window of on-chip registers. Any address that falls in none of these, or that lies beyond the currently configured ROM or RAM size, is reported as a memory exception. The ROM and RAM sizes are not fixed. Two small size codes, held in a configuration word inside the register window, set them. After reset the codes are zero, which gives the smallest sizes, so software must enlarge them before it touches higher memory.

The register window holds 64 words. A few of them steer the decoder: a control word with a protection enable bit, the size word, a wait-state word and two segment words. Every other offset in the window is plain storage that reads back what was written. No window offset ever raises an exception. With protection enabled, a RAM write must land inside one of two programmable segments, or it is refused with an exception. RAM reads are never checked.

A small sequencer accepts one access at a time. It states: `ST_IDLE` (ready for an access), `ST_WAIT` (counting wait states) and `ST_DONE` (a one-cycle response). Its transitions are: IDLE→DONE (an accepted access with zero wait states or an exception), IDLE→WAIT (an accepted access with a nonzero count), WAIT→WAIT (the count has not run out), WAIT→DONE (the last wait cycle) and DONE→IDLE (always). The response gives the region code, the wait count, the error flag and, for window reads, the stored word. The memory arrays themselves are not part of the block.

Top module: `memdec_top`

## Requirements
- R1: After reset every window word reads 0, the ROM size is 4 KB, the RAM size is 256 KB, all wait counts are 0 and protection is off. `acc_ready` is 1 and `resp_valid` is 0.
- R2: An address below 0x0008_0000 that is also below 4 KB shifted left by the ROM size code responds with region 1 (ROM). A code of 7 or more caps the size at 512 KB. Any other address in that space gives the error response.
- R3: An address 0x0200_0000 + off with off below 256 KB shifted left by the RAM size code responds with region 2 (RAM). A code of 4 or more caps the size at 4 MB. Any larger offset gives the error response.
- R4: Any address outside the ROM space, the RAM space and the window 0x01F8_0000–0x01F8_00FF gives the error response: `resp_err`=1, region 0, wait count 0. The error response arrives one cycle after acceptance.
- R5: Any address in the window responds with region 3, no error and wait count 0. A write stores the word at index addr[7:2]. A later read returns it in `resp_rdata`. The control word at offset 0x00 keeps only bit 3.
- R6: The size word at offset 0x10 holds the ROM code in bits [2:0] and the RAM code in bits [6:4]. A new value applies from the next accepted access.
- R7: The wait word at offset 0x18 holds the ROM count in bits [3:0], the RAM read count in bits [7:4] and the RAM write count in bits [11:8]. ROM writes use the ROM count. A non-error response reports the matching count N and arrives N+1 cycles after acceptance.
- R8: When bit 3 of the control word is 1, a RAM write is refused with the error response unless off[21:6] lies inclusively inside the segment of the word at 0x20 or of the word at 0x24. Each segment word holds its start in bits [15:0] and its end in bits [31:16]. RAM reads are unaffected, and with bit 3 clear no write is refused.
- R9: `acc_ready` is 1 only while idle, and `acc_valid` is taken only then. Each accepted access gives exactly one single-cycle `resp_valid` pulse, after which `acc_ready` returns. `resp_rdata` is 0 for every response except a window read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access request |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_addr | input | 32 | Byte address of the access |
| acc_wdata | input | 32 | Write data for window writes |
| acc_ready | output | 1 | Decoder is idle and takes a request |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_region | output | 2 | 0 none, 1 ROM, 2 RAM, 3 register window |
| resp_wait | output | 4 | Wait-state count applied to the access |
| resp_err | output | 1 | Memory exception |
| resp_rdata | output | 32 | Window read data, otherwise 0 |

## Verification
Wait-state insertion and the protection check can act on the same access: a RAM write outside both segments, made while the RAM write count is 5. The bench provokes this case after it has enabled protection and programmed both the segments and the wait word. It then drives writes just inside and just outside each segment edge. A refused write must respond after exactly one cycle, with the error set, region 0 and wait count 0. Its accepted neighbours must take six cycles and report a count of 5.

// File: rtl/memdec_pkg.sv
package memdec_pkg;

    localparam int WORD_W = 32;
    localparam int CODE_W = 3;
    localparam int NSEG   = 2;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_ROM  = 2'd1,
        RGN_RAM  = 2'd2,
        RGN_WIN  = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DONE = 2'd2
    } fsm_e;

    // word indices inside the register window (byte offset / 4)
    localparam int IDX_CTRL = 0;
    localparam int IDX_SIZE = 4;
    localparam int IDX_WAIT = 6;
    localparam int IDX_SEG0 = 8;
    localparam int IDX_SEG1 = 9;

    typedef struct packed {
        logic                          prot_en;
        logic [CODE_W-1:0]             rom_code;
        logic [CODE_W-1:0]             ram_code;
        logic [WORD_W-1:0]             wait_word;
        logic [NSEG-1:0][WORD_W-1:0]   segs;
    } cfg_t;

endpackage

// File: rtl/memdec_regfile.sv
module memdec_regfile
    import memdec_pkg::*;
#(
    parameter int WIN_WORDS     = 64,
    parameter int DATA_W        = 32,
    parameter int PROT_BIT      = 3,
    parameter int SIZE_ROM_LSB  = 0,
    parameter int SIZE_RAM_LSB  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [$clog2(WIN_WORDS)-1:0]  wr_idx,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [$clog2(WIN_WORDS)-1:0]  rd_idx,
    output logic [DATA_W-1:0]             rd_data,
    output cfg_t                          cfg
);
    localparam int IDX_W = $clog2(WIN_WORDS);

    logic [DATA_W-1:0] words [WIN_WORDS];

    // control word keeps only its protection bit; every other word keeps all bits
    function automatic logic [DATA_W-1:0] keep_mask(input logic [IDX_W-1:0] idx);
        if (idx == IDX_W'(IDX_CTRL)) begin
            return DATA_W'(1) << PROT_BIT;
        end
        return '1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WIN_WORDS; i++) begin
                words[i] <= '0;
            end
        end else if (wr_en) begin
            words[wr_idx] <= wr_data & keep_mask(wr_idx);
        end
    end

    assign rd_data = words[rd_idx];

    always_comb begin
        cfg           = '0;
        cfg.prot_en   = words[IDX_CTRL][PROT_BIT];
        cfg.rom_code  = words[IDX_SIZE][SIZE_ROM_LSB +: CODE_W];
        cfg.ram_code  = words[IDX_SIZE][SIZE_RAM_LSB +: CODE_W];
        cfg.wait_word = WORD_W'(words[IDX_WAIT]);
        cfg.segs[0]   = WORD_W'(words[IDX_SEG0]);
        cfg.segs[1]   = WORD_W'(words[IDX_SEG1]);
    end

    // R5: a plain window word holds exactly what was written
    a_r5_store_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx != IDX_W'(IDX_CTRL)) |=> (words[$past(wr_idx)] == $past(wr_data)));

    // R5: the control word never holds bits other than the protection bit
    a_r5_ctrl_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_W'(IDX_CTRL)) |=>
            ($countones(words[IDX_CTRL]) <= 1 && words[IDX_CTRL][PROT_BIT] == $past(wr_data[PROT_BIT])));

endmodule

// File: rtl/memdec_protect.sv
module memdec_protect
    import memdec_pkg::*;
#(
    parameter int OFS_W      = 22,
    parameter int GRAN_SHIFT = 6
) (
    input  logic                         prot_en,
    input  logic [OFS_W-1:0]             ram_off,
    input  logic [NSEG-1:0][WORD_W-1:0]  segs,
    output logic                         write_ok
);
    localparam int GRAN_W = OFS_W - GRAN_SHIFT;

    logic [GRAN_W-1:0] gran;
    logic [NSEG-1:0]   seg_hit;

    assign gran = ram_off[OFS_W-1:GRAN_SHIFT];

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        logic [GRAN_W-1:0] lo;
        logic [GRAN_W-1:0] hi;
        assign lo         = segs[g][GRAN_W-1:0];
        assign hi         = segs[g][2*GRAN_W-1:GRAN_W];
        assign seg_hit[g] = (gran >= lo) && (gran <= hi);
    end

    assign write_ok = !prot_en || (|seg_hit);

endmodule

// File: rtl/memdec_decode.sv
module memdec_decode
    import memdec_pkg::*;
#(
    parameter int          ADDR_W      = 32,
    parameter int          WS_W        = 4,
    parameter int          WIN_WORDS   = 64,
    parameter int          ROM_MIN_LOG = 12,
    parameter int          ROM_MAX_LOG = 19,
    parameter int          RAM_MIN_LOG = 18,
    parameter int          RAM_MAX_LOG = 22,
    parameter int          GRAN_SHIFT  = 6,
    parameter logic [31:0] RAM_BASE    = 32'h0200_0000,
    parameter logic [31:0] WIN_BASE    = 32'h01F8_0000
) (
    input  logic [ADDR_W-1:0]             addr,
    input  logic                          write,
    input  cfg_t                          cfg,
    output region_e                       rgn,
    output logic                          err,
    output logic [WS_W-1:0]               ws,
    output logic [$clog2(WIN_WORDS)-1:0]  win_idx
);
    localparam int IDX_W     = $clog2(WIN_WORDS);
    localparam int WIN_LOG   = IDX_W + 2;
    localparam int ROM_STEPS = ROM_MAX_LOG - ROM_MIN_LOG;
    localparam int RAM_STEPS = RAM_MAX_LOG - RAM_MIN_LOG;

    logic [ROM_MAX_LOG:0]   rom_lim;
    logic [RAM_MAX_LOG:0]   ram_lim;
    logic                   in_rom_space;
    logic                   in_ram_space;
    logic                   in_win;
    logic                   rom_ok;
    logic                   ram_ok;
    logic                   write_ok;
    logic [RAM_MAX_LOG-1:0] ram_off;
    logic [WS_W-1:0]        ws_rom;
    logic [WS_W-1:0]        ws_ram_rd;
    logic [WS_W-1:0]        ws_ram_wr;

    // programmable region sizes, each capped at its space
    always_comb begin
        if (int'(cfg.rom_code) >= ROM_STEPS) begin
            rom_lim = (ROM_MAX_LOG+1)'(1) << ROM_MAX_LOG;
        end else begin
            rom_lim = (ROM_MAX_LOG+1)'(1) << (ROM_MIN_LOG + int'(cfg.rom_code));
        end
        if (int'(cfg.ram_code) >= RAM_STEPS) begin
            ram_lim = (RAM_MAX_LOG+1)'(1) << RAM_MAX_LOG;
        end else begin
            ram_lim = (RAM_MAX_LOG+1)'(1) << (RAM_MIN_LOG + int'(cfg.ram_code));
        end
    end

    assign in_rom_space = (addr[ADDR_W-1:ROM_MAX_LOG] == '0);
    assign in_ram_space = (addr[ADDR_W-1:RAM_MAX_LOG] == RAM_BASE[ADDR_W-1:RAM_MAX_LOG]);
    assign in_win       = (addr[ADDR_W-1:WIN_LOG] == WIN_BASE[ADDR_W-1:WIN_LOG]);
    assign ram_off      = addr[RAM_MAX_LOG-1:0];
    assign rom_ok       = in_rom_space && ({1'b0, addr[ROM_MAX_LOG-1:0]} < rom_lim);
    assign ram_ok       = in_ram_space && ({1'b0, ram_off} < ram_lim);
    assign win_idx      = addr[WIN_LOG-1:2];

    assign ws_rom    = cfg.wait_word[WS_W-1:0];
    assign ws_ram_rd = cfg.wait_word[2*WS_W-1:WS_W];
    assign ws_ram_wr = cfg.wait_word[3*WS_W-1:2*WS_W];

    memdec_protect #(
        .OFS_W      (RAM_MAX_LOG),
        .GRAN_SHIFT (GRAN_SHIFT)
    ) u_protect (
        .prot_en  (cfg.prot_en),
        .ram_off  (ram_off),
        .segs     (cfg.segs),
        .write_ok (write_ok)
    );

    always_comb begin
        rgn = RGN_NONE;
        err = 1'b1;
        ws  = '0;
        if (in_win) begin
            rgn = RGN_WIN;
            err = 1'b0;
        end else if (rom_ok) begin
            rgn = RGN_ROM;
            err = 1'b0;
            ws  = ws_rom;
        end else if (ram_ok && (!write || write_ok)) begin
            rgn = RGN_RAM;
            err = 1'b0;
            ws  = write ? ws_ram_wr : ws_ram_rd;
        end
    end

endmodule

// File: rtl/memdec_fsm.sv
module memdec_fsm
    import memdec_pkg::*;
#(
    parameter int WS_W   = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  region_e           dec_rgn,
    input  logic              dec_err,
    input  logic [WS_W-1:0]   dec_ws,
    input  logic [DATA_W-1:0] cap_rdata,
    output logic              acc_ready,
    output logic              accept,
    output logic              resp_valid,
    output region_e           resp_region,
    output logic [WS_W-1:0]   resp_wait,
    output logic              resp_err,
    output logic [DATA_W-1:0] resp_rdata
);
    fsm_e              state_q;
    fsm_e              state_d;
    logic [WS_W-1:0]   cnt_q;
    region_e           rgn_q;
    logic              err_q;
    logic [WS_W-1:0]   ws_q;
    logic [DATA_W-1:0] rdata_q;

    assign accept = acc_valid && (state_q == ST_IDLE);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (acc_valid) begin
                    state_d = (dec_err || dec_ws == '0) ? ST_DONE : ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (cnt_q == WS_W'(1)) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // access capture and wait countdown
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            rgn_q   <= RGN_NONE;
            err_q   <= 1'b0;
            ws_q    <= '0;
            rdata_q <= '0;
        end else if (accept) begin
            cnt_q   <= dec_ws;
            rgn_q   <= dec_err ? RGN_NONE : dec_rgn;
            err_q   <= dec_err;
            ws_q    <= dec_err ? '0 : dec_ws;
            rdata_q <= cap_rdata;
        end else if (state_q == ST_WAIT) begin
            cnt_q <= cnt_q - WS_W'(1);
        end
    end

    // outputs
    always_comb begin
        acc_ready   = (state_q == ST_IDLE);
        resp_valid  = (state_q == ST_DONE);
        resp_region = RGN_NONE;
        resp_wait   = '0;
        resp_err    = 1'b0;
        resp_rdata  = '0;
        if (state_q == ST_DONE) begin
            resp_region = rgn_q;
            resp_wait   = ws_q;
            resp_err    = err_q;
            resp_rdata  = rdata_q;
        end
    end

    // R9: a response lasts one cycle
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R7: the wait counter steps down by one per waiting cycle
    a_r7_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && cnt_q != WS_W'(1)) |=>
            (state_q == ST_WAIT && cnt_q == $past(cnt_q) - WS_W'(1)));

    // R4: an exception carries no region and no wait count
    a_r4_err_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_err) |-> (resp_wait == '0 && resp_region == RGN_NONE));

    // R7: a zero-wait or refused access responds in the following cycle
    a_r7_direct_resp: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (dec_err || dec_ws == '0)) |=> resp_valid);

endmodule

// File: rtl/memdec_top.sv
module memdec_top
    import memdec_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int WS_W      = 4,
    parameter int WIN_WORDS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic              acc_ready,
    output logic              resp_valid,
    output logic [1:0]        resp_region,
    output logic [WS_W-1:0]   resp_wait,
    output logic              resp_err,
    output logic [DATA_W-1:0] resp_rdata
);
    localparam int IDX_W = $clog2(WIN_WORDS);

    cfg_t              cfg;
    region_e           dec_rgn;
    logic              dec_err;
    logic [WS_W-1:0]   dec_ws;
    logic [IDX_W-1:0]  win_idx;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] cap_rdata;
    logic              accept;
    logic              win_wr;
    region_e           rsp_rgn;

    assign win_wr    = accept && acc_write && (dec_rgn == RGN_WIN);
    assign cap_rdata = (dec_rgn == RGN_WIN && !acc_write) ? rd_data : '0;

    memdec_regfile #(
        .WIN_WORDS (WIN_WORDS),
        .DATA_W    (DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (win_wr),
        .wr_idx  (win_idx),
        .wr_data (acc_wdata),
        .rd_idx  (win_idx),
        .rd_data (rd_data),
        .cfg     (cfg)
    );

    memdec_decode #(
        .ADDR_W    (ADDR_W),
        .WS_W      (WS_W),
        .WIN_WORDS (WIN_WORDS)
    ) u_dec (
        .addr    (acc_addr),
        .write   (acc_write),
        .cfg     (cfg),
        .rgn     (dec_rgn),
        .err     (dec_err),
        .ws      (dec_ws),
        .win_idx (win_idx)
    );

    memdec_fsm #(
        .WS_W   (WS_W),
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid   (acc_valid),
        .dec_rgn     (dec_rgn),
        .dec_err     (dec_err),
        .dec_ws      (dec_ws),
        .cap_rdata   (cap_rdata),
        .acc_ready   (acc_ready),
        .accept      (accept),
        .resp_valid  (resp_valid),
        .resp_region (rsp_rgn),
        .resp_wait   (resp_wait),
        .resp_err    (resp_err),
        .resp_rdata  (resp_rdata)
    );

    assign resp_region = rsp_rgn;

    // R8: a refused write leaves every window word untouched
    a_r8_no_store_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dec_err) |-> !win_wr);

endmodule

// File: tb/sim_memdec_top.sv
module sim_memdec_top;

    localparam int CLK_PERIOD = 10;
    localparam int NV         = 37;

    typedef struct packed {
        logic [3:0]  rq;
        logic        wr;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [1:0]  rgn;
        logic        err;
        logic [3:0]  ws;
        logic [31:0] rdata;
    } vec_t;

    // requirement, write, address, write data, region, error, wait, read data
    localparam vec_t VECS [NV] = '{
        '{4'd1, 1'b0, 32'h01F8_0010, 32'h0, 2'd3, 1'b0, 4'd0, 32'h0},          // R1 size word cleared
        '{4'd1, 1'b0, 32'h01F8_0018, 32'h0, 2'd3, 1'b0, 4'd0, 32'h0},          // R1 wait word cleared
        '{4'd2, 1'b0, 32'h0000_0FFC, 32'h0, 2'd1, 1'b0, 4'd0, 32'h0},          // R2 last ROM word at 4 KB
        '{4'd2, 1'b0, 32'h0000_1000, 32'h0, 2'd0, 1'b1, 4'd0, 32'h0},          // R2 beyond 4 KB
        '{4'd3, 1'b0, 32'h0203_FFFC, 32'h0, 2'd2, 1'b0, 4'd0, 32'h0},          // R3 last RAM word at 256 KB
        '{4'd3, 1'b0, 32'h0204_0000, 32'h0, 2'd0, 1'b1, 4'd0, 32'h0},          // R3 beyond 256 KB
        '{4'd4, 1'b0, 32'h0100_0000, 32'h0, 2'd0, 1'b1, 4'd0, 32'h0},          // R4 hole
        '{4'd4, 1'b1, 32'h01F8_0100, 32'h1, 2'd0, 1'b1, 4'd0, 32'h0},          // R4 just past window
        '{4'd4, 1'b0, 32'h0240_0000, 32'h0, 2'd0, 1'b1, 4'd0, 32'h0},          // R4 past RAM space
        '{4'd5, 1'b1, 32'h01F8_00F0, 32'hA5A5_1234, 2'd3, 1'b0, 4'd0, 32'h0},  // R5 spare word write
        '{4'd5, 1'b0, 32'h01F8_00F0, 32'h0, 2'd3, 1'b0, 4'd0, 32'hA5A5_1234},  // R5 spare word read back
        '{4'd6, 1'b1, 32'h01F8_0010, 32'h0000_0027, 2'd3, 1'b0, 4'd0, 32'h0},  // R6 ROM code 7, RAM code 2
        '{4'd6, 1'b0, 32'h0007_FFFC, 32'h0, 2'd1, 1'b0, 4'd0, 32'h0},          // R6 ROM capped 512 KB
        '{4'd6, 1'b0, 32'h0008_0000, 32'h0, 2'd0, 1'b1, 4'd0, 32'h0},          // R6 past ROM space
        '{4'd6, 1'b0, 32'h020F_FFFC, 32'h0, 2'd2, 1'b0, 4'd0, 32'h0},          // R6 RAM 1 MB top
        '{4'd6, 1'b0, 32'h0210_0000, 32'h0, 2'd0, 1'b1, 4'd0, 32'h0},          // R6 RAM 1 MB past
        '{4'd7, 1'b1, 32'h01F8_0018, 32'h0000_0532, 2'd3, 1'b0, 4'd0, 32'h0},  // R7 rom 2, rd 3, wr 5
        '{4'd7, 1'b0, 32'h0000_0100, 32'h0, 2'd1, 1'b0, 4'd2, 32'h0},          // R7 ROM read
        '{4'd7, 1'b1, 32'h0000_0010, 32'h0, 2'd1, 1'b0, 4'd2, 32'h0},          // R7 ROM write
        '{4'd7, 1'b0, 32'h0200_0100, 32'h0, 2'd2, 1'b0, 4'd3, 32'h0},          // R7 RAM read
        '{4'd7, 1'b1, 32'h0200_0200, 32'h0, 2'd2, 1'b0, 4'd5, 32'h0},          // R7 RAM write, no protection
        '{4'd7, 1'b0, 32'h01F8_0018, 32'h0, 2'd3, 1'b0, 4'd0, 32'h0000_0532},  // R7 window has no waits
        '{4'd5, 1'b1, 32'h01F8_0000, 32'hFFFF_FFFF, 2'd3, 1'b0, 4'd0, 32'h0},  // R5 control write
        '{4'd5, 1'b0, 32'h01F8_0000, 32'h0, 2'd3, 1'b0, 4'd0, 32'h0000_0008},  // R5 control keeps bit 3
        '{4'd8, 1'b1, 32'h01F8_0020, 32'h0003_0001, 2'd3, 1'b0, 4'd0, 32'h0},  // R8 segment granules 1..3
        '{4'd8, 1'b1, 32'h01F8_0024, 32'h0010_0010, 2'd3, 1'b0, 4'd0, 32'h0},  // R8 segment granule 16
        '{4'd8, 1'b1, 32'h0200_0040, 32'h0, 2'd2, 1'b0, 4'd5, 32'h0},          // R8 first seg start
        '{4'd8, 1'b1, 32'h0200_00FC, 32'h0, 2'd2, 1'b0, 4'd5, 32'h0},          // R8 first seg end
        '{4'd8, 1'b1, 32'h0200_0100, 32'h0, 2'd0, 1'b1, 4'd0, 32'h0},          // R8 past first seg
        '{4'd8, 1'b1, 32'h0200_043C, 32'h0, 2'd2, 1'b0, 4'd5, 32'h0},          // R8 second seg
        '{4'd8, 1'b1, 32'h0200_0440, 32'h0, 2'd0, 1'b1, 4'd0, 32'h0},          // R8 past second seg
        '{4'd8, 1'b1, 32'h0200_003C, 32'h0, 2'd0, 1'b1, 4'd0, 32'h0},          // R8 below first seg
        '{4'd8, 1'b0, 32'h0200_003C, 32'h0, 2'd2, 1'b0, 4'd3, 32'h0},          // R8 read not checked
        '{4'd8, 1'b1, 32'h01F8_0000, 32'h0, 2'd3, 1'b0, 4'd0, 32'h0},          // R8 protection off
        '{4'd8, 1'b1, 32'h0200_003C, 32'h0, 2'd2, 1'b0, 4'd5, 32'h0},          // R8 write allowed again
        '{4'd6, 1'b1, 32'h01F8_0010, 32'h0000_0077, 2'd3, 1'b0, 4'd0, 32'h0},  // R6 RAM code 7
        '{4'd6, 1'b0, 32'h023F_FFFC, 32'h0, 2'd2, 1'b0, 4'd3, 32'h0}           // R6 RAM capped 4 MB
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic        acc_ready;
    logic        resp_valid;
    logic [1:0]  resp_region;
    logic [3:0]  resp_wait;
    logic        resp_err;
    logic [31:0] resp_rdata;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    memdec_top u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid   (acc_valid),
        .acc_write   (acc_write),
        .acc_addr    (acc_addr),
        .acc_wdata   (acc_wdata),
        .acc_ready   (acc_ready),
        .resp_valid  (resp_valid),
        .resp_region (resp_region),
        .resp_wait   (resp_wait),
        .resp_err    (resp_err),
        .resp_rdata  (resp_rdata)
    );

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (!(acc_ready === 1'b1 && resp_valid === 1'b0)) begin
            failures++;
            $display("FAIL R1 reset: actual ready=%0b valid=%0b expected ready=1 valid=0",
                     acc_ready, resp_valid);
        end
    endtask

    task automatic run_vec(input vec_t v);
        int lat;
        int exp_lat;
        while (acc_ready !== 1'b1) @(negedge clk);
        acc_valid = 1'b1;
        acc_write = v.wr;
        acc_addr  = v.addr;
        acc_wdata = v.wdata;
        @(negedge clk);
        acc_valid = 1'b0;
        lat = 1;
        while (resp_valid !== 1'b1 && lat < 64) begin
            @(negedge clk);
            lat++;
        end
        exp_lat = int'(v.ws) + 1;
        checks++;
        if (!(resp_valid === 1'b1 && resp_region === v.rgn && resp_err === v.err &&
              resp_wait === v.ws && resp_rdata === v.rdata && lat == exp_lat)) begin
            failures++;
            $display("FAIL R%0d addr=%h wr=%0b: actual rgn=%0d err=%0b wait=%0d rdata=%h lat=%0d expected rgn=%0d err=%0b wait=%0d rdata=%h lat=%0d",
                     v.rq, v.addr, v.wr, resp_region, resp_err, resp_wait, resp_rdata, lat,
                     v.rgn, v.err, v.ws, v.rdata, exp_lat);
        end
        @(negedge clk);
        checks++;   // R9 single pulse, ready returns
        if (!(resp_valid === 1'b0 && acc_ready === 1'b1)) begin
            failures++;
            $display("FAIL R9 after addr=%h: actual valid=%0b ready=%0b expected valid=0 ready=1",
                     v.addr, resp_valid, acc_ready);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R9 watchdog: actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        apply_reset();

        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i]);
        end

        // R9: a request held while busy is taken only once ready returns
        @(negedge clk);
        acc_valid = 1'b1;
        acc_write = 1'b0;
        acc_addr  = 32'h0200_0000;
        @(negedge clk);
        acc_valid = 1'b0;
        checks++;
        if (acc_ready !== 1'b0) begin
            failures++;
            $display("FAIL R9 busy: actual ready=%0b expected ready=0", acc_ready);
        end
        repeat (6) @(negedge clk);

        // R1: a second reset restores defaults
        apply_reset();
        run_vec('{4'd1, 1'b0, 32'h01F8_00F0, 32'h0, 2'd3, 1'b0, 4'd0, 32'h0});  // R1 spare word cleared
        run_vec('{4'd1, 1'b0, 32'h0000_1000, 32'h0, 2'd0, 1'b1, 4'd0, 32'h0});  // R1 ROM back to 4 KB
        run_vec('{4'd1, 1'b0, 32'h0204_0000, 32'h0, 2'd0, 1'b1, 4'd0, 32'h0});  // R1 RAM back to 256 KB
        run_vec('{4'd1, 1'b1, 32'h0200_0040, 32'h0, 2'd2, 1'b0, 4'd0, 32'h0});  // R1 waits and protection cleared

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule